// File: doc/BRIEF.md
# Flash Erase Command Controller

This controller sits between a byte-wide register write port and an on-chip flash array. Software arms an erase, loads a key value and then writes a command byte. The block checks the command byte against two fixed codes. It also checks the arming state and the key. If all the checks pass, it sends a one-cycle request to the flash macro, together with the page address and a flag that picks page or whole-array erase. It then stays busy until the macro reports completion.

The arming is one-shot. Loading a page address, or setting the whole-array enable, allows a single erase. When that erase completes, the controller clears the arming, so the next erase has to be armed again. Any write the controller refuses sets a sticky error flag. The next write that it accepts clears the flag.

The register select `wr_sel` picks one of four targets:

- 0 = command byte.
- 1 = page address, taken from `wr_data[5:0]`.
- 2 = whole-array enable, taken from `wr_data[0]`.
- 3 = key, taken from `wr_data[3:0]`.

Top module: `flash_erase_ctl`

## Requirements
- R1: When the key holds 2 and a page address has been loaded since the last completed erase, a command byte of 0x55 produces the following on the edge that samples the write: `erase_req` goes high, `erase_mass` is 0, `erase_page` shows the loaded page (0 to 63) and `busy` goes high.
- R2: When the key holds 2, the whole-array enable (select 2, bit 0) is 1 and `dbg_en` is high, a command byte of 0xAA raises `erase_req` and `busy` with `erase_mass` = 1.
- R3: A command byte other than 0x55 or 0xAA starts nothing and sets `err`.
- R4: A 0x55 command with no page address loaded since reset or since the last completed erase is refused: no request is made and `err` is set.
- R5: A 0xAA command is refused, with `err` set, if the whole-array enable is 0 or if `dbg_en` is low.
- R6: If the key (select 3, bits 3:0) holds any value other than 2, both erase commands are refused and `err` is set.
- R7: While `busy` is high, command writes and writes to select 1 or 2 are refused and set `err`, and `erase_page` does not change.
- R8: When `erase_done` arrives while `busy` is high, `busy` falls on the next edge and the page arming and the whole-array enable are cleared.
- R9: `err` stays set until a write is accepted. An accepted write clears it.
- R10: After reset, `busy`, `err`, `erase_req`, `erase_mass` and `erase_page` are all 0.
- R11: `erase_req` is high for exactly one cycle for each accepted erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 page, 2 whole-array enable, 3 key |
| wr_data | input | 8 | Write data |
| dbg_en | input | 1 | Debug port enabled; a whole-array erase needs this high |
| erase_done | input | 1 | Completion pulse from the flash macro |
| erase_req | output | 1 | One-cycle erase request to the flash macro |
| erase_mass | output | 1 | 1 = whole-array erase, 0 = single-page erase |
| erase_page | output | 6 | Page to erase |
| busy | output | 1 | Erase in progress |
| err | output | 1 | Sticky flag for a refused write |

## Verification
The hardest condition to reach from the ports is a write that arrives while an erase is still in flight. This window exists only between an accepted command and the macro's completion pulse. The bench's flash stub holds completion back for several cycles. In that window the bench issues a second command and a new page address. It then checks that the stub saw only one request and that the page output did not move. Re-arming is checked after completion, by repeating a command without loading a new page address or enable.

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter int          PAGE_W   = 6,
  parameter int          KEY_W    = 4,
  parameter int          KEY_VAL  = 2,
  parameter logic [7:0]  CMD_PAGE = 8'h55,
  parameter logic [7:0]  CMD_MASS = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              dbg_en,
  input  logic              erase_done,
  output logic              erase_req,
  output logic              erase_mass,
  output logic [PAGE_W-1:0] erase_page,
  output logic              busy,
  output logic              err
);
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_PAGE = 2'd1;
  localparam logic [1:0] SEL_MEN  = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;

  logic [KEY_W-1:0] key_q;
  logic             page_armed;
  logic             men_q;

  wire key_ok   = (key_q == KEY_W'(KEY_VAL));
  wire cmd_wr   = wr_en && (wr_sel == SEL_CMD);
  wire arm_wr   = wr_en && ((wr_sel == SEL_PAGE) || (wr_sel == SEL_MEN));
  wire go_page  = cmd_wr && !busy && key_ok && (wr_data == CMD_PAGE) && page_armed;
  wire go_mass  = cmd_wr && !busy && key_ok && (wr_data == CMD_MASS) && men_q && dbg_en;
  wire go       = go_page || go_mass;
  wire reject   = (cmd_wr && !go) || (arm_wr && busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_req  <= 1'b0;
      erase_mass <= 1'b0;
      erase_page <= '0;
      busy       <= 1'b0;
      err        <= 1'b0;
      key_q      <= '0;
      page_armed <= 1'b0;
      men_q      <= 1'b0;
    end else begin
      erase_req <= go;
      if (go) begin
        busy       <= 1'b1;
        erase_mass <= go_mass;
      end else if (busy && erase_done) begin
        busy       <= 1'b0;
        page_armed <= 1'b0;
        men_q      <= 1'b0;
      end
      if (wr_en && !busy && wr_sel == SEL_PAGE) begin
        erase_page <= wr_data[PAGE_W-1:0];
        page_armed <= 1'b1;
      end
      if (wr_en && !busy && wr_sel == SEL_MEN)
        men_q <= wr_data[0];
      if (wr_en && wr_sel == SEL_KEY)
        key_q <= wr_data[KEY_W-1:0];
      if (wr_en)
        err <= reject;
    end
  end

  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  // R1
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> busy);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_done) |=> busy);

  // R7
  page_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(erase_page));

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_done && !erase_req) |=> !busy);

  // R3
  req_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_req) |-> $past(wr_en && wr_sel == SEL_CMD));
endmodule

// File: tb/flash_erase_ctl_tb_top.sv
module flash_erase_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, dbg_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic erase_done = 0;
  logic erase_req, erase_mass, busy, err;
  logic [5:0] erase_page;
  int n_chk = 0, n_fail = 0;
  int stub_cnt = 0;
  logic [5:0] stub_page = 0;
  logic stub_mass = 0;
  int lat = 0;

  always #2 clk = ~clk;

  flash_erase_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dbg_en(dbg_en), .erase_done(erase_done), .erase_req(erase_req),
    .erase_mass(erase_mass), .erase_page(erase_page), .busy(busy), .err(err)
  );

  always @(posedge clk) begin
    erase_done <= 1'b0;
    if (erase_req) begin
      stub_cnt  <= stub_cnt + 1;
      stub_page <= erase_page;
      stub_mass <= erase_mass;
      lat       <= 6;
    end else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) erase_done <= 1'b1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy, 0);
    chk("R10 err", err, 0);
    chk("R10 req", erase_req, 0);
    chk("R10 mass", erase_mass, 0);
    chk("R10 page", erase_page, 0);
  endtask

  task automatic t_page();
    int c0 = stub_cnt;
    wr(3, 8'h02);
    wr(1, 8'd37);
    wr(0, 8'h55);
    chk("R1 req", erase_req, 1);
    chk("R1 busy", busy, 1);
    chk("R1 mass", erase_mass, 0);
    chk("R1 page", erase_page, 37);
    @(negedge clk);
    chk("R11 req low", erase_req, 0);
    wait_idle();
    chk("R8 busy cleared", busy, 0);
    chk("R1 stub page", stub_page, 37);
    chk("R11 one request", stub_cnt - c0, 1);
    chk("R9 err clear", err, 0);
  endtask

  task automatic t_rearm();
    int c0 = stub_cnt;
    wr(0, 8'h55);
    chk("R4 no req", erase_req, 0);
    chk("R4 err", err, 1);
    wr(1, 8'd63);
    chk("R9 err cleared", err, 0);
    wr(0, 8'h55);
    chk("R1 page 63 req", erase_req, 1);
    chk("R1 page 63", erase_page, 63);
    wait_idle();
    chk("R4 count", stub_cnt - c0, 1);
  endtask

  task automatic t_bad();
    int c0 = stub_cnt;
    wr(1, 8'd4);
    wr(0, 8'h54);
    chk("R3 0x54 busy", busy, 0);
    chk("R3 0x54 err", err, 1);
    wr(0, 8'h00);
    chk("R3 0x00 err", err, 1);
    wr(0, 8'hFF);
    chk("R3 0xFF busy", busy, 0);
    @(negedge clk);
    chk("R3 no requests", stub_cnt - c0, 0);
  endtask

  task automatic t_key();
    int c0 = stub_cnt;
    wr(3, 8'h03);
    wr(1, 8'd9);
    wr(0, 8'h55);
    chk("R6 page busy", busy, 0);
    chk("R6 page err", err, 1);
    dbg_en = 1;
    wr(2, 8'h01);
    wr(0, 8'hAA);
    chk("R6 mass busy", busy, 0);
    chk("R6 no requests", stub_cnt - c0, 0);
    wr(3, 8'h02);
    chk("R9 key write clears err", err, 0);
    wr(0, 8'h55);
    chk("R6 key ok page", erase_page, 9);
    chk("R6 key ok busy", busy, 1);
    wait_idle();
  endtask

  task automatic t_mass();
    int c0 = stub_cnt;
    dbg_en = 0;
    wr(2, 8'h01);
    wr(0, 8'hAA);
    chk("R5 no dbg busy", busy, 0);
    chk("R5 no dbg err", err, 1);
    dbg_en = 1;
    wr(2, 8'h00);
    wr(0, 8'hAA);
    chk("R5 no enable busy", busy, 0);
    wr(2, 8'h01);
    wr(0, 8'hAA);
    chk("R2 req", erase_req, 1);
    chk("R2 mass", erase_mass, 1);
    wait_idle();
    chk("R2 stub mass", stub_mass, 1);
    wr(0, 8'hAA);
    chk("R8 enable cleared", busy, 0);
    chk("R8 err", err, 1);
    chk("R2 count", stub_cnt - c0, 1);
  endtask

  task automatic t_busy();
    int c0 = stub_cnt;
    wr(1, 8'd12);
    wr(0, 8'h55);
    chk("R7 started", busy, 1);
    wr(0, 8'h55);
    chk("R7 cmd during busy err", err, 1);
    wr(1, 8'd20);
    chk("R7 page held", erase_page, 12);
    chk("R7 still busy", busy, 1);
    wait_idle();
    chk("R7 one request", stub_cnt - c0, 1);
    chk("R7 page after", erase_page, 12);
    wr(0, 8'h55);
    chk("R8 page arm cleared", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_page();
    t_rearm();
    t_bad();
    t_key();
    t_mass();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule